// File: doc/BRIEF.md
# Externally Synchronized Frame Timing Generator

This block generates the horizontal and vertical timing of an image sensor raster. A column counter sweeps each line through a programmable active width followed by horizontal blanking, and a row counter walks the frame through a programmable active height followed by vertical blanking. From the two counters the block decodes a horizontal sync, a vertical sync and a data-valid strobe. The counters themselves are also exported, so downstream pixel logic knows its position in the raster.

Frame starts follow an external frame-sync input. The input is resynchronized and edge-detected, and a rising edge requests a new frame. The request is honoured only at the end of the line in progress, so no line is ever cut short. A request that arrives before the programmed frame is complete ends that frame early. If the programmed frame completes with no request seen, the block appends blanking lines one at a time until a request comes. The number of such padding lines is latched when the next frame starts. Sensors fed the same pulse therefore begin their frames within one line of each other.

A free-run mode bit removes the dependence on the input. In that mode, frames repeat at the programmed height and sync edges are discarded.

Top module: `frame_sync_timing`

## Requirements
- R1: While reset is high and in the first sample after its release, `col`, `row` and `pad_lines` are all zero.
- R2: `col` counts 0 to `cfg_act_w + cfg_hblank - 1` once per clock and then wraps to 0. `hsync` is high exactly when `col >= cfg_act_w`, so each line has `cfg_hblank` hsync cycles.
- R3: `de` is high exactly when `col < cfg_act_w` and `row < cfg_act_h`. The frame holds `cfg_act_w * cfg_act_h` data-valid cycles, and padding lines hold none.
- R4: `vsync` is high exactly when `row >= cfg_act_h`, which covers vertical blanking and all padding lines.
- R5: With `cfg_free_run` high, a frame lasts `(cfg_act_h + cfg_vblank)` lines and `row` returns to 0 after the last of them. Rising edges on `fsync_in` have no effect on frame timing.
- R6: With `cfg_free_run` low and no pending request, `row` keeps incrementing past the programmed height, one padding line per line time. It saturates at its all-ones value.
- R7: With `cfg_free_run` low, suppose `fsync_in` is first sampled high at clock edge k. Then `row` and `col` both become 0 at the first edge at or after k+2 that ends a line. The latency from k is therefore at most one line plus two cycles, and the line in progress always completes.
- R8: A sync pulse lasting one clock, and ending well before the line boundary, is held as pending and still restarts the frame at that boundary.
- R9: At each frame restart, `pad_lines` takes the value max(0, last row + 1 - (`cfg_act_h + cfg_vblank`)). It changes at no other time, and it is 0 for frames that end at or before the programmed height.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_free_run | input | 1 | 1: repeat frames at programmed height, ignore sync input |
| cfg_act_w | input | COL_W | Active pixels per line (at least 1) |
| cfg_hblank | input | COL_W | Horizontal blanking cycles per line (at least 1) |
| cfg_act_h | input | ROW_W | Active lines per frame (at least 1) |
| cfg_vblank | input | ROW_W | Vertical blanking lines per programmed frame |
| fsync_in | input | 1 | Asynchronous frame-sync input, rising edge requests a frame start |
| hsync | output | 1 | Horizontal blanking/sync indicator |
| vsync | output | 1 | Vertical blanking/sync indicator, includes padding lines |
| de | output | 1 | Data-valid strobe for active pixels |
| col | output | COL_W | Current column |
| row | output | ROW_W | Current row, continues past programmed height while padding |
| pad_lines | output | ROW_W | Padding lines inserted in the last completed frame |

## Verification
The bench builds the block with an 8-bit column counter and a 5-bit row counter. With these widths, waiting through enough padding lines to reach row saturation takes only a few hundred cycles, so the saturated row value and the largest padding count are both exercised. Short lines and small frames put every line boundary within a few cycles of a sync edge. This lets the restart latency be checked against every column phase, including an edge detected exactly at the end of a line.

// File: rtl/fsg_pkg.sv
package fsg_pkg;

    // Synchronizer depth ahead of the edge detector.
    parameter int unsigned FSYNC_STAGES = 2;

    // What the row counter does at a clock edge.
    typedef enum logic [1:0] {
        ROW_HOLD    = 2'd0,
        ROW_NEXT    = 2'd1,
        ROW_RESTART = 2'd2
    } row_step_e;

    // Decoded timing strobes.
    typedef struct packed {
        logic hsync;
        logic vsync;
        logic de;
    } timing_flags_t;

    // Pick the row step from line boundary, request and frame-end state.
    function automatic row_step_e pick_step(input logic line_end,
                                            input logic sync_req,
                                            input logic free_run,
                                            input logic last_prog);
        if (!line_end)
            return ROW_HOLD;
        else if (sync_req || (free_run && last_prog))
            return ROW_RESTART;
        else
            return ROW_NEXT;
    endfunction

endpackage

// File: rtl/fsg_sync_edge.sv
module fsg_sync_edge #(
    parameter int unsigned STAGES = fsg_pkg::FSYNC_STAGES
) (
    input  logic clk,
    input  logic rst,
    input  logic async_in,
    output logic rise
);
    // STAGES synchronizer flops plus one history flop for edge detection.
    logic [STAGES:0] chain_q;

    genvar g;
    generate
        for (g = 0; g <= STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain_q[g] <= 1'b0;
                    else     chain_q[g] <= async_in;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain_q[g] <= 1'b0;
                    else     chain_q[g] <= chain_q[g-1];
                end
            end
        end
    endgenerate

    assign rise = chain_q[STAGES-1] & ~chain_q[STAGES];
endmodule

// File: rtl/fsg_line_ctr.sv
module fsg_line_ctr #(
    parameter int unsigned COL_W = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [COL_W-1:0] act_w,
    input  logic [COL_W-1:0] hblank,
    output logic [COL_W-1:0] col,
    output logic             line_end
);
    logic [COL_W:0]   line_len;
    logic [COL_W-1:0] col_q;

    assign line_len = {1'b0, act_w} + {1'b0, hblank};
    assign line_end = ({1'b0, col_q} == (line_len - 1'b1));

    always_ff @(posedge clk) begin
        if (rst)           col_q <= '0;
        else if (line_end) col_q <= '0;
        else               col_q <= col_q + 1'b1;
    end

    assign col = col_q;
endmodule

// File: rtl/fsg_frame_ctr.sv
module fsg_frame_ctr
    import fsg_pkg::*;
#(
    parameter int unsigned ROW_W = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             line_end,
    input  logic             free_run,
    input  logic             sync_rise,
    input  logic [ROW_W-1:0] act_h,
    input  logic [ROW_W-1:0] vblank,
    output logic [ROW_W-1:0] row,
    output logic [ROW_W-1:0] pad_lines,
    output logic             sync_req
);
    localparam logic [ROW_W-1:0] ROW_MAX = '1;

    logic [ROW_W-1:0] row_q, pad_q;
    logic             pend_q;
    logic [ROW_W:0]   frame_h, next_cnt, over;
    logic             last_prog;
    row_step_e        step;

    assign frame_h   = {1'b0, act_h} + {1'b0, vblank};
    assign next_cnt  = {1'b0, row_q} + 1'b1;
    assign last_prog = (next_cnt >= frame_h);
    // Negative difference (top bit set) means the frame ended early.
    assign over      = next_cnt - frame_h;

    assign sync_req = !free_run && (pend_q || sync_rise);
    assign step     = pick_step(line_end, sync_req, free_run, last_prog);

    always_ff @(posedge clk) begin
        if (rst) begin
            row_q  <= '0;
            pad_q  <= '0;
            pend_q <= 1'b0;
        end else begin
            unique case (step)
                ROW_RESTART: begin
                    row_q  <= '0;
                    pad_q  <= over[ROW_W] ? '0 : over[ROW_W-1:0];
                    pend_q <= 1'b0;
                end
                ROW_NEXT: begin
                    if (row_q != ROW_MAX) row_q <= row_q + 1'b1;
                    pend_q <= sync_req;
                end
                default: begin
                    pend_q <= sync_req;
                end
            endcase
        end
    end

    assign row       = row_q;
    assign pad_lines = pad_q;
endmodule

// File: rtl/frame_sync_timing.sv
module frame_sync_timing
    import fsg_pkg::*;
#(
    parameter int unsigned COL_W = 12,
    parameter int unsigned ROW_W = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_free_run,
    input  logic [COL_W-1:0] cfg_act_w,
    input  logic [COL_W-1:0] cfg_hblank,
    input  logic [ROW_W-1:0] cfg_act_h,
    input  logic [ROW_W-1:0] cfg_vblank,
    input  logic             fsync_in,
    output logic             hsync,
    output logic             vsync,
    output logic             de,
    output logic [COL_W-1:0] col,
    output logic [ROW_W-1:0] row,
    output logic [ROW_W-1:0] pad_lines
);
    logic          sync_rise;
    logic          line_end;
    logic          sync_req;
    timing_flags_t flags;

    fsg_sync_edge #(.STAGES(FSYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst      (rst),
        .async_in (fsync_in),
        .rise     (sync_rise)
    );

    fsg_line_ctr #(.COL_W(COL_W)) u_line (
        .clk      (clk),
        .rst      (rst),
        .act_w    (cfg_act_w),
        .hblank   (cfg_hblank),
        .col      (col),
        .line_end (line_end)
    );

    fsg_frame_ctr #(.ROW_W(ROW_W)) u_frame (
        .clk       (clk),
        .rst       (rst),
        .line_end  (line_end),
        .free_run  (cfg_free_run),
        .sync_rise (sync_rise),
        .act_h     (cfg_act_h),
        .vblank    (cfg_vblank),
        .row       (row),
        .pad_lines (pad_lines),
        .sync_req  (sync_req)
    );

    always_comb begin
        flags.hsync = (col >= cfg_act_w);
        flags.vsync = (row >= cfg_act_h);
        flags.de    = (col < cfg_act_w) && (row < cfg_act_h);
    end

    assign hsync = flags.hsync;
    assign vsync = flags.vsync;
    assign de    = flags.de;
endmodule

// File: rtl/frame_sync_timing_chk.sv
module frame_sync_timing_chk #(
    parameter int unsigned COL_W = 12,
    parameter int unsigned ROW_W = 12
) (
    input logic             clk,
    input logic             rst,
    input logic             cfg_free_run,
    input logic [ROW_W-1:0] cfg_act_h,
    input logic [ROW_W-1:0] cfg_vblank,
    input logic             hsync,
    input logic             vsync,
    input logic             de,
    input logic [COL_W-1:0] col,
    input logic [ROW_W-1:0] row,
    input logic [ROW_W-1:0] pad_lines,
    input logic             line_end,
    input logic             sync_req
);
    logic [ROW_W:0] fh;
    logic [ROW_W:0] rn;
    assign fh = {1'b0, cfg_act_h} + {1'b0, cfg_vblank};
    assign rn = {1'b0, row} + 1'b1;

    assert_col_wrap_R2: assert property (@(posedge clk) disable iff (rst)
        line_end |=> (col == '0));
    assert_col_step_R2: assert property (@(posedge clk) disable iff (rst)
        !line_end |=> (col == $past(col) + 1'b1));
    assert_end_in_blank_R2: assert property (@(posedge clk) disable iff (rst)
        line_end |-> hsync);
    assert_de_excl_R3: assert property (@(posedge clk) disable iff (rst)
        de |-> (!vsync && !hsync));
    assert_free_wrap_R5: assert property (@(posedge clk) disable iff (rst)
        (cfg_free_run && line_end && rn == fh) |=> (row == '0));
    assert_pad_grow_R6: assert property (@(posedge clk) disable iff (rst)
        (!cfg_free_run && line_end && !sync_req && rn >= fh && row != '1)
        |=> (row == $past(row) + 1'b1));
    assert_sync_restart_R7: assert property (@(posedge clk) disable iff (rst)
        (line_end && sync_req) |=> (row == '0 && col == '0));
    assert_row_hold_R7: assert property (@(posedge clk) disable iff (rst)
        !line_end |=> $stable(row));
    assert_pad_update_R9: assert property (@(posedge clk) disable iff (rst)
        (pad_lines != $past(pad_lines)) |-> (row == '0 && col == '0));
endmodule

bind frame_sync_timing frame_sync_timing_chk #(.COL_W(COL_W), .ROW_W(ROW_W)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .cfg_free_run (cfg_free_run),
    .cfg_act_h    (cfg_act_h),
    .cfg_vblank   (cfg_vblank),
    .hsync        (hsync),
    .vsync        (vsync),
    .de           (de),
    .col          (col),
    .row          (row),
    .pad_lines    (pad_lines),
    .line_end     (line_end),
    .sync_req     (sync_req)
);

// File: tb/frame_sync_timing_tb.sv
module frame_sync_timing_tb;
    localparam int COL_W = 8;
    localparam int ROW_W = 5;
    localparam int ROW_MAX = (1 << ROW_W) - 1;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             cfg_free_run = 1'b0;
    logic [COL_W-1:0] cfg_act_w = 8'd6;
    logic [COL_W-1:0] cfg_hblank = 8'd2;
    logic [ROW_W-1:0] cfg_act_h = 5'd4;
    logic [ROW_W-1:0] cfg_vblank = 5'd2;
    logic             fsync_in = 1'b0;
    logic             hsync, vsync, de;
    logic [COL_W-1:0] col;
    logic [ROW_W-1:0] row, pad_lines;

    int n_checks = 0;
    int n_fail   = 0;
    int L = 8;
    int H = 6;

    always #4 clk = ~clk;

    frame_sync_timing #(.COL_W(COL_W), .ROW_W(ROW_W)) u_dut (
        .clk(clk), .rst(rst), .cfg_free_run(cfg_free_run),
        .cfg_act_w(cfg_act_w), .cfg_hblank(cfg_hblank),
        .cfg_act_h(cfg_act_h), .cfg_vblank(cfg_vblank),
        .fsync_in(fsync_in), .hsync(hsync), .vsync(vsync), .de(de),
        .col(col), .row(row), .pad_lines(pad_lines)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    function automatic int exp_pad(input int last_row, input int height);
        return (last_row + 1 > height) ? last_row + 1 - height : 0;
    endfunction

    task automatic restart(input int aw, input int hb, input int ah, input int vb, input bit fr);
        rst = 1'b1;
        cfg_act_w = COL_W'(aw); cfg_hblank = COL_W'(hb);
        cfg_act_h = ROW_W'(ah); cfg_vblank = ROW_W'(vb);
        cfg_free_run = fr;
        fsync_in = 1'b0;
        L = aw + hb; H = ah + vb;
        step(); step(); step();
        rst = 1'b0;
        check(col == 0 && row == 0, "R1 position after reset", int'(row) * 256 + int'(col), 0);
        check(pad_lines == 0, "R1 pad count after reset", int'(pad_lines), 0);
    endtask

    // Pulse fsync for 'hold' samples, wait for the expected restart boundary.
    task automatic do_sync(input int hold, output int r_last);
        int c, waits;
        fsync_in = 1'b1;
        step(); if (hold <= 1) fsync_in = 1'b0;
        step(); if (hold <= 2) fsync_in = 1'b0;
        c = int'(col);
        r_last = int'(row);
        waits = (c == L - 1) ? 1 : 1 + (L - 1 - c);
        for (int i = 0; i < waits; i++) begin
            r_last = int'(row);
            step();
        end
        fsync_in = 1'b0;
        check(row == 0 && col == 0, "R7 restart at first line end after sync",
              int'(row) * 256 + int'(col), 0);
        check(2 + waits <= L + 2, "R7 latency within one line", 2 + waits, L + 2);
    endtask

    task automatic free_frame_checks(input int aw, input int hb, input int ah, input int vb, input bit poke);
        int n_de, n_vs, n_hs;
        n_de = 0; n_vs = 0; n_hs = 0;
        for (int i = 0; i < H * L; i++) begin
            if (de) n_de++;
            if (vsync) n_vs++;
            if (hsync) n_hs++;
            if (poke && i == 3) fsync_in = 1'b1;
            if (poke && i == 7) fsync_in = 1'b0;
            step();
        end
        check(n_de == aw * ah, "R3 data-valid cycles per frame", n_de, aw * ah);
        check(n_vs == vb * L, "R4 vsync cycles per frame", n_vs, vb * L);
        check(n_hs == hb * H, "R2 hsync cycles per frame", n_hs, hb * H);
        check(row == 0 && col == 0, "R5 free-run frame period", int'(row) * 256 + int'(col), 0);
        check(pad_lines == 0, "R9 no padding in free run", int'(pad_lines), 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("  End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        int r_last, n_hs, n_de, aw, hb, ah, vb, wait_n, hold;
        bit fr;
        void'($urandom(32'd1729));

        // Slave mode, aw=6 hb=2 ah=4 vb=2 -> L=8, H=6.
        restart(6, 2, 4, 2, 1'b0);
        check(de == 1'b1, "R3 de at first pixel", int'(de), 1);
        n_hs = 0; n_de = 0;
        for (int i = 0; i < L; i++) begin
            if (hsync) n_hs++;
            if (de) n_de++;
            step();
        end
        check(n_hs == 2, "R2 hsync cycles per line", n_hs, 2);
        check(n_de == 6, "R3 de cycles per active line", n_de, 6);
        check(col == 0 && row == 1, "R2 line wrap after line length", int'(row) * 256 + int'(col), 1 * 256);

        // Padding: no sync through row H+3.
        repeat ((H + 2) * L) step();
        check(int'(row) == H + 3, "R6 padding lines continue past height", int'(row), H + 3);
        n_de = 0;
        for (int i = 0; i < L; i++) begin
            if (de) n_de++;
            check(vsync == 1'b1, "R4 vsync during padding", int'(vsync), 1);
            step();
        end
        check(n_de == 0, "R6 no data-valid in padding line", n_de, 0);
        do_sync(3, r_last);
        check(int'(pad_lines) == exp_pad(r_last, H), "R9 pad count after padded frame",
              int'(pad_lines), exp_pad(r_last, H));
        check(int'(pad_lines) == 5, "R9 pad count value", int'(pad_lines), 5);

        // Early short pulse inside an active line.
        repeat (L + 3) step();
        do_sync(1, r_last);
        check(r_last == 1, "R8 one-cycle pulse restarts at line end", r_last, 1);
        check(pad_lines == 0, "R9 early frame has no padding", int'(pad_lines), 0);

        // Sync detected exactly at a line end: sample at col=L-3 -> edge seen at col L-1.
        while (int'(col) != L - 3) step();
        do_sync(1, r_last);

        // Row saturation.
        repeat ((ROW_MAX + 6) * L) step();
        check(int'(row) == ROW_MAX, "R6 row saturates", int'(row), ROW_MAX);
        do_sync(2, r_last);
        check(int'(pad_lines) == ROW_MAX + 1 - H, "R9 pad count at saturation",
              int'(pad_lines), ROW_MAX + 1 - H);

        // Free run, with a sync pulse that must be ignored.
        restart(6, 2, 4, 2, 1'b1);
        free_frame_checks(6, 2, 4, 2, 1'b0);
        free_frame_checks(6, 2, 4, 2, 1'b1);

        // Constrained random configurations.
        for (int it = 0; it < 10; it++) begin
            aw = 1 + int'($urandom_range(19));
            hb = 1 + int'($urandom_range(5));
            ah = 1 + int'($urandom_range(7));
            vb = int'($urandom_range(4));
            fr = 1'($urandom_range(1));
            restart(aw, hb, ah, vb, fr);
            if (fr) begin
                free_frame_checks(aw, hb, ah, vb, 1'b1);
            end else begin
                wait_n = int'($urandom_range((H + 4) * L));
                hold = 1 + int'($urandom_range(2));
                repeat (wait_n) step();
                do_sync(hold, r_last);
                check(int'(pad_lines) == exp_pad(r_last, H), "R9 random pad count",
                      int'(pad_lines), exp_pad(r_last, H));
                repeat (3) step();
                do_sync(1, r_last);
            end
        end

        $display("  End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule